// File: doc/BRIEF.md
# I2C Quarter-Phase Bit Engine

This block is the bit-level half of an I2C master. A host hands it one command at a time: a START condition, a STOP condition, a byte transmit, a byte receive with a chosen acknowledge level, or a bus-recovery sequence that frees a slave stuck part-way through a byte. The engine drives SCL directly and controls SDA as an open-drain pull-down enable. For a transmit it returns the acknowledge bit the slave put on the wire. For a receive it returns the assembled byte.

All bus timing is built from one time unit equal to a quarter of an SCL bit period. A free-running divider, cleared when a command is accepted, marks the end of each unit. Each command is a fixed list of units, grouped into bit slots, and each unit sets the SCL and SDA levels for its whole length. The SDA pin is read through a two-stage synchroniser, and it is sampled only at the end of the units that the protocol names.

Top module: `i2cb_engine`

## Requirements
- R1: After reset SCL is high, SDA is released (`sda_oe`=0), and `busy` and `done` are both low.
- R2: Each unit lasts exactly UNIT_DIV clock cycles. Counted from the accepting clock edge, a command takes START 4 units, STOP 4, byte transmit 37, byte receive 29 and recovery 40. `done` rises at the edge that ends the last unit.
- R3: START, unit by unit: levels held, then SDA released, then SCL high, then SDA pulled low while SCL stays high.
- R4: STOP, unit by unit: SCL low, then SDA pulled low, then SCL high, then SDA released while SCL is high.
- R5: A byte transmit sends bit 7 first. Each bit takes four units: SCL low, then the data level on SDA with SCL still low, then two units of SCL high.
- R6: After the eighth data bit the engine releases SDA while SCL is low and holds SCL high for two units. At the end of that high time it samples SDA into `ack_bit` (0 = acknowledged, 1 = not acknowledged). One final unit with SCL low follows.
- R7: A byte receive releases SDA and clocks 8 bits, each being one unit of SCL low and two units of SCL high. SDA is sampled at the end of the first high unit, and the byte is assembled with bit 7 first.
- R8: After a received byte the engine drives its own acknowledge: SCL low one unit, SDA at the `rd_nack` level captured at acceptance (0 pulls low, 1 releases) with SCL still low, SCL high for two units, then SCL low for one unit.
- R9: Recovery: nine pulses, each SCL low for two units then high for two units, with SDA released throughout, followed by a STOP as in R4.
- R10: A command is accepted only when `busy` is low and `cmd_code` is 0 (recovery), 1 (START), 2 (STOP), 3 (transmit) or 4 (receive). Codes 5 to 7 and any request made while busy leave the bus and `busy` unchanged.
- R11: `busy` is high from the accepting edge until the end of the command. `done` is a one-cycle pulse that coincides with `busy` falling, and `ack_bit` and `rx_byte` hold the command's result in that cycle.
- R12: SCL and SDA change only at the accepting edge or at a unit boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_code | input | 3 | Command selector (see R10) |
| wr_byte | input | 8 | Byte to transmit |
| rd_nack | input | 1 | Acknowledge level to send after a received byte |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_byte | output | 8 | Received byte |
| ack_bit | output | 1 | Acknowledge level sampled after a transmit |
| scl_o | output | 1 | SCL level driven onto the bus |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | SDA level read back from the bus |

## Verification
The hardest case to reach from the ports is a slave whose response must land in the correct unit despite the synchroniser delay. The bench models an open-drain slave. At the start of each unit it sets its pull-down from that unit's index, so the value is stable more than two cycles before the sampling edge. It drives receive bits in their three-unit slots and pulls SDA only during the acknowledge slot. This shows that bit order, the sampling unit and the acknowledge capture all line up. A second request held high for the whole length of a START checks that a busy engine ignores it.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  typedef enum logic [2:0] {
    OP_RECOVER = 3'd0,
    OP_START   = 3'd1,
    OP_STOP    = 3'd2,
    OP_WRITE   = 3'd3,
    OP_READ    = 3'd4
  } op_e;

  localparam int GRP_W = 4;
  localparam int PH_W  = 3;
endpackage

// File: rtl/i2cb_qtick.sv
module i2cb_qtick #(
  parameter int UNIT_DIV = 1250
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int CW = (UNIT_DIV > 2) ? $clog2(UNIT_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(UNIT_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr || !run) cnt <= '0;
    else if (cnt == LAST)   cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/i2cb_sync.sv
module i2cb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2cb_phase_rom.sv
module i2cb_phase_rom
  import i2cb_pkg::*;
(
  input  op_e              op,
  input  logic [GRP_W-1:0] grp,
  input  logic [PH_W-1:0]  ph,
  input  logic             dbit,
  input  logic             ackl,
  input  logic             cur_scl,
  input  logic             cur_rel,
  output logic             scl,
  output logic             rel,
  output logic             smp,
  output logic             ph_last,
  output logic             grp_last
);
  always_comb begin
    scl      = cur_scl;
    rel      = cur_rel;
    smp      = 1'b0;
    ph_last  = (ph == PH_W'(3));
    grp_last = 1'b1;
    case (op)
      OP_RECOVER: begin
        grp_last = (grp == GRP_W'(9));
        if (grp < GRP_W'(9)) begin
          rel = 1'b1;
          if (ph == PH_W'(0))      scl = 1'b0;
          else if (ph == PH_W'(2)) scl = 1'b1;
        end else begin
          case (ph)
            PH_W'(0): scl = 1'b0;
            PH_W'(1): rel = 1'b0;
            PH_W'(2): scl = 1'b1;
            default:  rel = 1'b1;
          endcase
        end
      end
      OP_START: begin
        case (ph)
          PH_W'(1): rel = 1'b1;
          PH_W'(2): scl = 1'b1;
          PH_W'(3): rel = 1'b0;
          default: ;
        endcase
      end
      OP_STOP: begin
        case (ph)
          PH_W'(0): scl = 1'b0;
          PH_W'(1): rel = 1'b0;
          PH_W'(2): scl = 1'b1;
          default:  rel = 1'b1;
        endcase
      end
      OP_WRITE: begin
        grp_last = (grp == GRP_W'(9));
        if (grp < GRP_W'(9)) begin
          case (ph)
            PH_W'(0): scl = 1'b0;
            PH_W'(1): rel = (grp == GRP_W'(8)) ? 1'b1 : dbit;
            PH_W'(2): scl = 1'b1;
            default:  smp = (grp == GRP_W'(8));
          endcase
        end else begin
          scl     = 1'b0;
          ph_last = 1'b1;
        end
      end
      OP_READ: begin
        grp_last = (grp == GRP_W'(8));
        if (grp < GRP_W'(8)) begin
          ph_last = (ph == PH_W'(2));
          if (ph == PH_W'(0)) begin
            scl = 1'b0;
            rel = 1'b1;
          end else if (ph == PH_W'(1)) begin
            scl = 1'b1;
            smp = 1'b1;
          end
        end else begin
          ph_last = (ph == PH_W'(4));
          case (ph)
            PH_W'(0): scl = 1'b0;
            PH_W'(1): rel = ackl;
            PH_W'(2): scl = 1'b1;
            PH_W'(4): scl = 1'b0;
            default: ;
          endcase
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/i2cb_engine.sv
module i2cb_engine
  import i2cb_pkg::*;
#(
  parameter int UNIT_DIV    = 1250,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  input  logic [7:0] wr_byte,
  input  logic       rd_nack,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       ack_bit,
  output logic       scl_o,
  output logic       sda_oe,
  input  logic       sda_i
);
  op_e              op_q;
  logic [GRP_W-1:0] grp_q, n_grp;
  logic [PH_W-1:0]  ph_q, n_ph;
  logic [7:0]       sh_q, n_sh;
  logic             ackl_q, scl_q, rel_q;
  logic             tick, sda_s, accept, legal, adv, fin;
  logic             c_scl, c_rel, c_smp, c_phl, c_grl;
  logic             n_scl, n_rel, n_smp, n_phl, n_grl;
  op_e              sel_op;
  logic             sel_ackl;

  assign legal  = (cmd_code <= 3'd4);
  assign accept = cmd_valid && !busy && legal;
  assign fin    = c_phl && c_grl;
  assign adv    = busy && tick && !fin;

  i2cb_qtick #(.UNIT_DIV(UNIT_DIV)) u_tick (
    .clk(clk), .rst(rst), .run(busy), .clr(accept), .tick(tick)
  );

  i2cb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(sda_i), .dout(sda_s)
  );

  // Decode of the unit in progress: sampling and end-of-command flags.
  i2cb_phase_rom u_cur (
    .op(op_q), .grp(grp_q), .ph(ph_q), .dbit(sh_q[7]), .ackl(ackl_q),
    .cur_scl(scl_q), .cur_rel(rel_q),
    .scl(c_scl), .rel(c_rel), .smp(c_smp), .ph_last(c_phl), .grp_last(c_grl)
  );

  always_comb begin
    sel_op   = op_q;
    sel_ackl = ackl_q;
    n_grp    = grp_q;
    n_ph     = ph_q;
    n_sh     = sh_q;
    if (accept) begin
      sel_op   = op_e'(cmd_code);
      sel_ackl = rd_nack;
      n_grp    = '0;
      n_ph     = '0;
      n_sh     = wr_byte;
    end else if (c_phl) begin
      n_grp = grp_q + 1'b1;
      n_ph  = '0;
      n_sh  = {sh_q[6:0], 1'b0};
    end else begin
      n_ph  = ph_q + 1'b1;
    end
  end

  // Decode of the unit about to begin: the levels it applies.
  i2cb_phase_rom u_nxt (
    .op(sel_op), .grp(n_grp), .ph(n_ph), .dbit(n_sh[7]), .ackl(sel_ackl),
    .cur_scl(scl_q), .cur_rel(rel_q),
    .scl(n_scl), .rel(n_rel), .smp(n_smp), .ph_last(n_phl), .grp_last(n_grl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q    <= OP_RECOVER;
      grp_q   <= '0;
      ph_q    <= '0;
      sh_q    <= '0;
      ackl_q  <= 1'b1;
      scl_q   <= 1'b1;
      rel_q   <= 1'b1;
      busy    <= 1'b0;
      done    <= 1'b0;
      rx_byte <= '0;
      ack_bit <= 1'b1;
    end else begin
      done <= 1'b0;
      if (accept) begin
        op_q   <= sel_op;
        ackl_q <= sel_ackl;
        grp_q  <= n_grp;
        ph_q   <= n_ph;
        sh_q   <= n_sh;
        scl_q  <= n_scl;
        rel_q  <= n_rel;
        busy   <= 1'b1;
      end else if (busy && tick) begin
        if (c_smp) begin
          if (op_q == OP_WRITE) ack_bit <= sda_s;
          else                  rx_byte <= {rx_byte[6:0], sda_s};
        end
        if (fin) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else if (adv) begin
          grp_q <= n_grp;
          ph_q  <= n_ph;
          sh_q  <= n_sh;
          scl_q <= n_scl;
          rel_q <= n_rel;
        end
      end
    end
  end

  assign scl_o  = scl_q;
  assign sda_oe = ~rel_q;
endmodule

// File: rtl/i2cb_engine_chk.sv
module i2cb_engine_chk #(
  parameter int UNIT_DIV = 1250
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic scl_o,
  input logic sda_oe
);
  localparam int CW = (UNIT_DIV > 2) ? $clog2(UNIT_DIV) : 1;
  logic [CW-1:0] ucnt;

  always_ff @(posedge clk) begin
    if (rst || !busy)                 ucnt <= '0;
    else if (ucnt == CW'(UNIT_DIV-1)) ucnt <= '0;
    else                              ucnt <= ucnt + 1'b1;
  end

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> ($stable(scl_o) && $stable(sda_oe)));

  // R12
  unit_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(scl_o) || !$stable(sda_oe)) |-> (busy && ucnt == '0));
endmodule

bind i2cb_engine i2cb_engine_chk #(.UNIT_DIV(UNIT_DIV)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .scl_o(scl_o), .sda_oe(sda_oe)
);

// File: tb/i2cb_engine_bench.sv
`timescale 1ns/1ps
module i2cb_engine_bench;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic [7:0] wr_byte = 8'h00;
  logic       rd_nack = 1'b0;
  logic       busy, done, ack_bit, scl_o, sda_oe;
  logic [7:0] rx_byte;
  logic       pull = 1'b0;
  logic       sda_i;
  int         errors = 0;
  int         checks = 0;
  bit         finished = 1'b0;

  always #2 clk = ~clk;
  assign sda_i = ~(sda_oe | pull);

  i2cb_engine #(.UNIT_DIV(DIV)) u_i2cb_engine (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .wr_byte(wr_byte), .rd_nack(rd_nack), .busy(busy), .done(done),
    .rx_byte(rx_byte), .ack_bit(ack_bit), .scl_o(scl_o), .sda_oe(sda_oe),
    .sda_i(sda_i)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int units_of(input int op);
    case (op)
      0: return 40;
      3: return 37;
      4: return 29;
      default: return 4;
    endcase
  endfunction

  // Expected levels for unit k: cs/cr mark whether SCL/SDA is checked there.
  task automatic expect_unit(input int op, input int k, input logic [7:0] wb, input bit ackl,
                             output bit cs, output bit es, output bit cr, output bit er);
    int p;
    cs = 1; cr = 1; es = 0; er = 1;
    if (op == 1) begin
      case (k)
        0: begin cs = 0; cr = 0; end
        1: begin cs = 0; er = 1; end
        2: begin es = 1; er = 1; end
        default: begin es = 1; er = 0; end
      endcase
    end else if (op == 2 || (op == 0 && k >= 36)) begin
      p = k % 4;
      es = (p >= 2);
      er = (p == 3);
      if (p == 0) cr = 0;
    end else if (op == 0) begin
      es = ((k % 4) >= 2); er = 1;
    end else if (op == 3) begin
      if (k < 32) begin
        p = k % 4;
        es = (p >= 2);
        er = wb[7 - k/4];
        if (p == 0) cr = 0;
      end else if (k == 32) begin es = 0; cr = 0; end
      else if (k == 36) begin es = 0; er = 1; end
      else begin es = (k >= 34); er = 1; end
    end else begin
      if (k < 24) begin es = ((k % 3) != 0); er = 1; end
      else if (k == 24) begin es = 0; cr = 0; end
      else begin es = (k == 26 || k == 27); er = ackl; end
    end
  endtask

  // Runs one command with a bus slave model and checks every unit.
  task automatic run_cmd(input int op, input logic [7:0] wb, input bit ackl,
                         input bit slave_nack, input logic [7:0] sbyte,
                         input bit hold_req, input string req);
    int n;
    bit cs, es, cr, er;
    n = units_of(op);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 3'(op); wr_byte = wb; rd_nack = ackl;
    @(posedge clk);
    @(negedge clk);
    if (hold_req) begin cmd_code = 3'd2; wr_byte = ~wb; rd_nack = ~ackl; end
    else cmd_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      expect_unit(op, k, wb, ackl, cs, es, cr, er);
      if (cs) chk(scl_o == es, {req, " scl"}, scl_o, es);
      if (cr) chk(sda_oe == !er, {req, " sda_oe"}, sda_oe, !er);
      chk(busy && !done, "R11 busy during command", {busy, done}, 2);
      if (op == 3) pull = (k >= 33 && k <= 35) && !slave_nack;
      else if (op == 4) pull = (k < 24) ? !sbyte[7 - k/3] : 1'b0;
      else pull = 1'b0;
      if (k == n - 1) cmd_valid = 1'b0;
      repeat (DIV) @(negedge clk);
    end
    pull = 1'b0;
    chk(done && !busy, "R2 done at end of last unit", {done, busy}, 2);
    if (op == 3) chk(ack_bit == slave_nack, "R6 ack_bit", ack_bit, slave_nack);
    if (op == 4) chk(rx_byte == sbyte, "R7 rx_byte", rx_byte, sbyte);
    @(negedge clk);
    chk(!done && !busy, "R11 done one cycle, no new command", {done, busy}, 0);
  endtask

  task automatic test_reset;
    chk(scl_o == 1'b1, "R1 scl after reset", scl_o, 1);
    chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
    chk(!busy && !done, "R1 busy/done after reset", {busy, done}, 0);
  endtask

  task automatic test_bad_code;
    logic s0, d0;
    s0 = scl_o; d0 = sda_oe;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 3'd6;
    repeat (3 * DIV) @(negedge clk);
    chk(!busy, "R10 unknown code busy", busy, 0);
    chk(scl_o == s0 && sda_oe == d0, "R10 unknown code bus", {scl_o, sda_oe}, {s0, d0});
    cmd_code = 3'd7;
    repeat (DIV) @(negedge clk);
    chk(!busy && !done, "R10 code 7 ignored", {busy, done}, 0);
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    run_cmd(0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, "R9 recovery");
    run_cmd(1, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, "R3 R10 start");
    run_cmd(3, 8'hA5, 1'b1, 1'b0, 8'h00, 1'b0, "R5 write A5");
    run_cmd(3, 8'h3C, 1'b1, 1'b1, 8'h00, 1'b0, "R5 R6 write 3C nack");
    run_cmd(1, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, "R3 repeated start");
    run_cmd(4, 8'h00, 1'b0, 1'b0, 8'hC3, 1'b0, "R7 R8 read ack");
    run_cmd(4, 8'h00, 1'b1, 1'b0, 8'h5A, 1'b0, "R7 R8 read nack");
    run_cmd(2, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, "R4 stop");
    test_bad_code();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule